// File: doc/BRIEF.md
# Reference-Switch Capture Range Controller

This block chooses the phase-capture range of a clock-recovery loop each time that loop moves to a new input reference. After a reference change it first asks the loop for nearest-edge capture (±180 degrees), so that the loop pulls in without slipping a whole cycle. If the loop does not report phase lock within a fixed window, the block widens capture to the combined frequency-and-phase range (±360 degrees). A control input can force the wide range at all times.

The window is counted in ticks of a clock-enable input, so the same logic covers a two-second window in the chip and a few ticks in simulation. The block reports its state and a flag that says the last window ran out. It also has a small edge picker for the 8 kHz reference path. This picker turns the selected edge of that signal (rising or falling) into a one-cycle pulse.

Top module: `capture_range_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it rises, `mode_state_o` is 0 (idle), and `full_range_o`, `timed_out_o` and `ref8k_edge_o` are 0.
- R2: With `force_full_i` low, a clock edge that samples `ref_switch_i` high puts the block in nearest-edge state (code 1) in the next cycle, from any state. It also restarts the window from zero.
- R3: In nearest-edge state without phase lock, the edge that samples the `WINDOW_TICKS`-th `cap_tick_i` after the reference change moves the block to full-range state (code 2) and sets `timed_out_o`. Before that tick the block stays in nearest-edge state.
- R4: A clock edge that samples `force_full_i` high puts the block in full-range state in the next cycle. The block never shows nearest-edge state while `force_full_i` was high at the previous edge.
- R5: If `phase_lock_i` is sampled high in nearest-edge state, the window is cancelled. The block stays in nearest-edge state through any number of later ticks, even after the lock indication drops.
- R6: Full-range state is left only by a reference change. Ticks, phase lock and the release of `force_full_i` do not leave it.
- R7: `timed_out_o` is set only by the expiry of a window and is cleared by an edge that samples `ref_switch_i` high.
- R8: With `edge_pol_i` = 1, `ref8k_edge_o` pulses for one cycle after an edge where `ref8k_i` is sampled 1 and was sampled 0 at the previous edge. With `edge_pol_i` = 0 the pulse follows a sampled 1-to-0 change instead.
- R9: State codes on `mode_state_o` are idle = 0, nearest-edge = 1, full-range = 2, and code 3 never appears. `full_range_o` is 1 exactly when the code is 2.
- R10: A tick sampled at the same edge as a reference change is not counted. Ticks and phase lock have no effect in idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_tick_i | input | 1 | Timebase clock-enable for the capture window |
| ref_switch_i | input | 1 | Pulse: the loop has moved to a new reference |
| phase_lock_i | input | 1 | Phase-lock indication from the loop |
| force_full_i | input | 1 | 1 forces full-range (±360°) capture |
| edge_pol_i | input | 1 | 8 kHz edge select: 1 rising, 0 falling |
| ref8k_i | input | 1 | 8 kHz reference, already synchronous to `clk` |
| mode_state_o | output | 2 | State code: 0 idle, 1 nearest-edge, 2 full-range |
| full_range_o | output | 1 | 1 selects ±360° capture, 0 selects ±180° |
| timed_out_o | output | 1 | The last window expired without phase lock |
| ref8k_edge_o | output | 1 | One-cycle pulse on the selected 8 kHz edge |

## Verification
The assertions assume that every input is synchronous to `clk` and is stable around the sampling edge. They also assume that `ref8k_i` has already been brought into the clock domain. The assertions do not assume that `ref_switch_i` is a single-cycle pulse or that `force_full_i` is quiet during a window.

The stimulus changes every input only between clock edges. Random phases deliberately overlap reference changes, ticks, lock and force in the same cycle, so the priority between them is exercised. Directed phases line up exactly on the expiring tick.

// File: rtl/capture_range_pkg.sv
// Shared types for the capture range controller.
// Assumes: state codes are seen on a port, so the values are fixed.
package capture_range_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_NEAR = 2'd1,
        ST_FULL = 2'd2
    } cap_state_e;

endpackage

// File: rtl/capture_window_timer.sv
// Counts timebase ticks while the window runs and flags the last tick.
// Assumes: LIMIT >= 1; clr has priority over counting; the expire flag
// is combinational and valid only in the cycle of the final tick.
module capture_window_timer #(
    parameter int LIMIT = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  logic tick,
    output logic expire
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    // Tick counter: cleared on request, advances on counted ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (run && tick) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    // Final-tick detect.
    always_comb begin
        expire = run && tick && (cnt_q == LAST);
    end
endmodule

// File: rtl/capture_mode_fsm.sv
// Capture-mode state machine: idle, nearest-edge, full-range.
// Assumes: force has priority over a reference change, which has priority
// over lock and timer events; expire comes from the window timer.
module capture_mode_fsm
    import capture_range_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_switch,
    input  logic       phase_lock,
    input  logic       force_full,
    input  logic       expire,
    output cap_state_e state,
    output logic       timer_run,
    output logic       timer_clr,
    output logic       timed_out
);
    cap_state_e state_q, state_d;
    logic       lock_seen_q;
    logic       timed_out_q;

    // Timer control: run only in an open, unlocked window.
    always_comb begin
        timer_clr = ref_switch || force_full;
        timer_run = (state_q == ST_NEAR) && !lock_seen_q && !phase_lock
                    && !ref_switch && !force_full;
    end

    // Next-state selection in priority order.
    always_comb begin
        state_d = state_q;
        if (force_full) begin
            state_d = ST_FULL;
        end else if (ref_switch) begin
            state_d = ST_NEAR;
        end else if (expire) begin
            state_d = ST_FULL;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Lock memory: once lock is seen in a window, the timeout is cancelled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_seen_q <= 1'b0;
        end else if (ref_switch || force_full) begin
            lock_seen_q <= 1'b0;
        end else if (state_q == ST_NEAR && phase_lock) begin
            lock_seen_q <= 1'b1;
        end
    end

    // Timeout flag: set by expiry, cleared by a new reference.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timed_out_q <= 1'b0;
        end else if (ref_switch) begin
            timed_out_q <= 1'b0;
        end else if (expire) begin
            timed_out_q <= 1'b1;
        end
    end

    assign state     = state_q;
    assign timed_out = timed_out_q;
endmodule

// File: rtl/ref8k_edge_pick.sv
// Turns the selected edge of the 8 kHz reference into a one-cycle pulse.
// Assumes: the input is already synchronous; the history bit resets to 0.
module ref8k_edge_pick (
    input  logic clk,
    input  logic rst_n,
    input  logic pol_rise,
    input  logic sig_in,
    output logic edge_out
);
    logic prev_q;
    logic pulse_q;

    // History bit and registered edge pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            prev_q  <= sig_in;
            pulse_q <= pol_rise ? (sig_in && !prev_q) : (!sig_in && prev_q);
        end
    end

    assign edge_out = pulse_q;
endmodule

// File: rtl/capture_range_ctrl.sv
// Top level: capture range controller for a reference switch.
// Assumes: all inputs are synchronous to clk; WINDOW_TICKS is the window
// length in cap_tick_i pulses (two seconds in the target timebase).
module capture_range_ctrl
    import capture_range_pkg::*;
#(
    parameter int WINDOW_TICKS = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cap_tick_i,
    input  logic       ref_switch_i,
    input  logic       phase_lock_i,
    input  logic       force_full_i,
    input  logic       edge_pol_i,
    input  logic       ref8k_i,
    output logic [1:0] mode_state_o,
    output logic       full_range_o,
    output logic       timed_out_o,
    output logic       ref8k_edge_o
);
    cap_state_e state_w;
    logic       run_w;
    logic       clr_w;
    logic       expire_w;

    capture_window_timer #(.LIMIT(WINDOW_TICKS)) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr_w),
        .run    (run_w),
        .tick   (cap_tick_i),
        .expire (expire_w)
    );

    capture_mode_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_switch (ref_switch_i),
        .phase_lock (phase_lock_i),
        .force_full (force_full_i),
        .expire     (expire_w),
        .state      (state_w),
        .timer_run  (run_w),
        .timer_clr  (clr_w),
        .timed_out  (timed_out_o)
    );

    ref8k_edge_pick edge_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pol_rise (edge_pol_i),
        .sig_in   (ref8k_i),
        .edge_out (ref8k_edge_o)
    );

    // Port view of the state and the capture-range select.
    always_comb begin
        mode_state_o = state_w;
        full_range_o = (state_w == ST_FULL);
    end
endmodule

// File: rtl/capture_range_chk.sv
// Port-level checker for capture_range_ctrl, attached with bind.
// Assumes: inputs are synchronous to clk.
module capture_range_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ref_switch_i,
    input logic       phase_lock_i,
    input logic       force_full_i,
    input logic       edge_pol_i,
    input logic       ref8k_i,
    input logic [1:0] mode_state_o,
    input logic       full_range_o,
    input logic       timed_out_o,
    input logic       ref8k_edge_o
);
    // R2: an unforced reference change opens nearest-edge capture
    p_switch_near_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_switch_i && !force_full_i) |=> (mode_state_o == 2'd1));

    // R4: force gives full range at the next cycle
    p_force_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        force_full_i |=> (full_range_o && mode_state_o == 2'd2));

    // R5: lock in the window keeps nearest-edge capture
    p_lock_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_state_o == 2'd1 && phase_lock_i && !ref_switch_i && !force_full_i)
        |=> (mode_state_o == 2'd1));

    // R6: full range persists without a reference change
    p_full_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_state_o == 2'd2 && !ref_switch_i) |=> (mode_state_o == 2'd2));

    // R7: timeout flag rises only out of nearest-edge capture
    p_timeout_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timed_out_o) |-> ($past(mode_state_o) == 2'd1 && mode_state_o == 2'd2));

    // R7: a reference change clears the timeout flag
    p_timeout_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ref_switch_i |=> !timed_out_o);

    // R8: a pulse follows a sample that matches the selected polarity
    p_edge_pol_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ref8k_edge_o |-> ($past(ref8k_i) == $past(edge_pol_i)));

    // R9: legal state code and consistent range select
    p_state_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_state_o != 2'd3) && (full_range_o == (mode_state_o == 2'd2)));
endmodule

bind capture_range_ctrl capture_range_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ref_switch_i (ref_switch_i),
    .phase_lock_i (phase_lock_i),
    .force_full_i (force_full_i),
    .edge_pol_i   (edge_pol_i),
    .ref8k_i      (ref8k_i),
    .mode_state_o (mode_state_o),
    .full_range_o (full_range_o),
    .timed_out_o  (timed_out_o),
    .ref8k_edge_o (ref8k_edge_o)
);

// File: tb/capture_range_ctrl_tb_top.sv
// Bench for capture_range_ctrl: directed corners plus seeded random traffic,
// compared every cycle against a model built from the requirements.
module capture_range_ctrl_tb_top;
    localparam int WIN = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, refsw = 1'b0, lock = 1'b0, force_f = 1'b0;
    logic       pol = 1'b1, r8k = 1'b0;
    logic [1:0] st_o;
    logic       full_o, tmo_o, edge_o;

    int compared = 0;
    int mismatched = 0;
    string cur_req = "R1";

    // model state
    int m_st = 0, m_cnt = 0;
    bit m_seen = 0, m_tmo = 0, m_prev = 0, m_edge = 0;

    always #10 clk = ~clk;

    capture_range_ctrl #(.WINDOW_TICKS(WIN)) dut_i (
        .clk(clk), .rst_n(rst_n), .cap_tick_i(tick), .ref_switch_i(refsw),
        .phase_lock_i(lock), .force_full_i(force_f), .edge_pol_i(pol),
        .ref8k_i(r8k), .mode_state_o(st_o), .full_range_o(full_o),
        .timed_out_o(tmo_o), .ref8k_edge_o(edge_o)
    );

    function automatic bit exp_edge(bit p, bit now, bit prev);
        return p ? (now && !prev) : (!now && prev);
    endfunction

    task automatic model_step();
        bit expire;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_seen = 0; m_tmo = 0; m_prev = 0; m_edge = 0;
            return;
        end
        m_edge = exp_edge(pol, r8k, m_prev);
        m_prev = r8k;
        expire = 0;
        if (force_f) begin
            m_st = 2; m_cnt = 0; m_seen = 0;
        end else if (refsw) begin
            m_st = 1; m_cnt = 0; m_seen = 0;
        end else if (m_st == 1) begin
            if (lock) m_seen = 1;
            else if (!m_seen && tick) begin
                if (m_cnt == WIN - 1) begin
                    expire = 1; m_st = 2; m_cnt = 0;
                end else m_cnt++;
            end
        end
        if (refsw) m_tmo = 0;
        else if (expire) m_tmo = 1;
    endtask

    task automatic chk(string what, int got, int exp);
        compared++;
        if (got != exp) begin
            mismatched++;
            $display("FAIL %s %s got %0d expected %0d at %0t", cur_req, what, got, exp, $time);
        end
    endtask

    task automatic check_all();
        chk("mode_state_o (R9)", st_o, m_st);
        chk("full_range_o (R9)", full_o, (m_st == 2));
        chk("timed_out_o", tmo_o, m_tmo);
        chk("ref8k_edge_o", edge_o, m_edge);
    endtask

    // One cycle: inputs already set between edges; update model at the edge.
    task automatic cyc(bit t, bit r, bit l, bit f);
        tick = t; refsw = r; lock = l; force_f = f;
        @(posedge clk);
        model_step();
        #5;
        check_all();
    endtask

    initial begin
        #(20 * 200000);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        // R1: reset state
        cur_req = "R1";
        repeat (3) cyc(1, 1, 1, 0);
        rst_n = 1'b1;
        cyc(0, 0, 0, 0);
        chk("R1 idle code", st_o, 0);

        // R10: ticks and lock ignored in idle
        cur_req = "R10";
        repeat (12) cyc(1, 0, 1, 0);
        chk("R10 still idle", st_o, 0);

        // R2 + R3: switch, tick in same cycle not counted, expiry on WIN-th tick
        cur_req = "R2";
        cyc(1, 1, 0, 0);
        chk("R2 near after switch", st_o, 1);
        cur_req = "R3";
        for (int i = 0; i < WIN - 1; i++) begin
            cyc(1, 0, 0, 0);
            cyc(0, 0, 0, 0);
        end
        chk("R3 near before last tick", st_o, 1);
        cyc(1, 0, 0, 0);
        chk("R3 full after last tick", st_o, 2);
        chk("R3 timeout set", tmo_o, 1);

        // R6: full range ignores ticks and lock
        cur_req = "R6";
        repeat (20) cyc(1, 0, 1, 0);
        chk("R6 full held", st_o, 2);

        // R7 + R2: switch from full clears flag and restarts window
        cur_req = "R7";
        cyc(0, 1, 0, 0);
        chk("R7 flag cleared", tmo_o, 0);
        chk("R2 restart from full", st_o, 1);

        // R5: lock cancels the window, even after lock drops
        cur_req = "R5";
        repeat (3) cyc(1, 0, 0, 0);
        cyc(1, 0, 1, 0);
        repeat (3 * WIN) cyc(1, 0, 0, 0);
        chk("R5 stays near", st_o, 1);
        chk("R5 no timeout", tmo_o, 0);

        // R2: restart mid-window delays the expiry
        cur_req = "R2";
        cyc(0, 1, 0, 0);
        repeat (WIN - 2) cyc(1, 0, 0, 0);
        cyc(1, 1, 0, 0);
        repeat (WIN - 1) cyc(1, 0, 0, 0);
        chk("R2 window restarted", st_o, 1);
        cyc(1, 0, 0, 0);
        chk("R2 expiry after restart", st_o, 2);

        // R4: force beats a switch; release keeps full (R6)
        cur_req = "R4";
        cyc(0, 1, 0, 1);
        chk("R4 forced full", st_o, 2);
        repeat (5) cyc(1, 1, 1, 1);
        chk("R4 still full", st_o, 2);
        cur_req = "R6";
        cyc(0, 0, 0, 0);
        chk("R6 full after release", st_o, 2);

        // R8: edge polarity, both settings
        cur_req = "R8";
        pol = 1'b1; r8k = 1'b1; cyc(0, 0, 0, 0);
        chk("R8 rising pulse", edge_o, 1);
        r8k = 1'b0; cyc(0, 0, 0, 0);
        chk("R8 no pulse on fall", edge_o, 0);
        pol = 1'b0; r8k = 1'b1; cyc(0, 0, 0, 0);
        chk("R8 no pulse on rise", edge_o, 0);
        r8k = 1'b0; cyc(0, 0, 0, 0);
        chk("R8 falling pulse", edge_o, 1);

        // Random traffic across all requirements
        cur_req = "R3";
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 99) == 0) pol = ~pol;
            if ($urandom_range(0, 3) == 0) r8k = ~r8k;
            if ($urandom_range(0, 149) == 0) force_f = ~force_f;
            cyc(($urandom_range(0, 2) == 0), ($urandom_range(0, 39) == 0),
                ($urandom_range(0, 29) == 0), force_f);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule